// File: doc/BRIEF.md
# Host I/O Port Snoop FIFO

This block listens to host I/O write cycles, presented as a single-cycle write strobe with a 16-bit port address and an 8-bit data byte, and keeps the bytes written to up to two programmable port numbers. Every kept byte goes into a 16-entry hardware FIFO along with a one-bit tag saying where it came from. A management processor reaches the block through a small byte-wide register port. Through that port it sets the two port numbers and the enables, polls status, pops bytes and acknowledges host-reset events. An interrupt line tells it when there is work to do.

There is also a double-word capture mode. In that mode the second port number is not used, and the block takes a window of four consecutive byte ports that starts at the first port number. The tag then marks the byte that closes each four-byte group. A separate event flag records every change of level on the asynchronous host reset input.

Top module: `io_snoop_fifo`

## Requirements
- R1: After reset every readable register reads 0x00 and irq_o is low.
- R2: Port number one is {offset 0x12, offset 0x10} and port number two is {offset 0x04, offset 0x02}, each written as a high byte and a low byte. Each reads back the value written, and the enable byte at offset 0x06 reads back too.
- R3: With bit 2 of the enable byte clear, a host write to port one is captured when enable bit 7 is set, with tag 0. A write to port two is captured when enable bit 6 is set, with tag 1. If both ports hold the same number, port one wins. Writes to any other address, and writes to a disabled port, are not captured.
- R4: The status byte at offset 0x08 gives bit 7 = FIFO not empty, bit 5 = overflow and bit 0 = tag of the head entry. Every other bit reads 0, and bit 0 reads 0 when the FIFO is empty.
- R5: A read of offset 0x0A returns the head byte and pops it, so bytes come out in arrival order. A read of 0x0A while the FIFO is empty returns 0x00 and changes nothing.
- R6: The FIFO holds 16 entries. A host capture that arrives while it is full is dropped and sets the overflow bit, unless a pop happens in the same cycle.
- R7: The overflow bit stays set until a status read happens while the FIFO is empty. A status read while data remains does not clear it.
- R8: With enable bit 2 set, host writes to the four addresses from port one up to port one + 3 are captured, whatever the state of bits 7 and 6. Only the write to port one + 3 carries tag 1. Port two is ignored.
- R9: host_rst_i passes through two synchronising flops. Each rising or falling edge then sets bit 6 of offset 0x0C within four clock cycles.
- R10: Writing a byte with bit 6 set to offset 0x0C clears that flag, and writing bit 6 = 0 leaves it alone. If a new edge arrives in the same cycle as the clear, the flag stays set.
- R11: irq_o is a level. It is high while (FIFO not empty and enable bit 3) or (reset flag and enable bit 4), and low otherwise.
- R12: Register writes to offsets 0x08, 0x0A and to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host I/O write strobe, one cycle per write |
| host_addr_i | input | 16 | Host I/O port address |
| host_data_i | input | 8 | Host I/O write data |
| host_rst_i | input | 1 | Asynchronous host reset level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops on data offset) |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench fills the FIFO past its depth and then checks two things: that the seventeenth byte was dropped rather than overwriting the oldest entry, and that the overflow bit survives a status read made while data remains. A design that wrapped its write pointer would return the wrong first byte, and one that cleared overflow on any status read would show bit 5 low too early. In double-word mode the bench writes all four window addresses plus port two and an address just below the window. This catches a matcher that tags the wrong byte, or that leaks port-two captures or out-of-window writes into the FIFO. It toggles host reset in both directions and writes 0 and then 1 to the flag, which catches a detector that only sees one edge or a clear that is not write-one.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int OFS_W  = 5;

  typedef enum logic [OFS_W-1:0] {
    OFS_P2_LO = 5'h02,
    OFS_P2_HI = 5'h04,
    OFS_CTRL  = 5'h06,
    OFS_STAT  = 5'h08,
    OFS_DATA  = 5'h0A,
    OFS_HRST  = 5'h0C,
    OFS_P1_LO = 5'h10,
    OFS_P1_HI = 5'h12
  } reg_ofs_e;

  // control bit positions
  localparam int CTL_P1_EN   = 7;
  localparam int CTL_P2_EN   = 6;
  localparam int CTL_HRST_IE = 4;
  localparam int CTL_RDY_IE  = 3;
  localparam int CTL_DWORD   = 2;

  // status bit positions
  localparam int ST_VALID = 7;
  localparam int ST_OVF   = 5;
  localparam int ST_TAG   = 0;
  localparam int HR_FLAG  = 6;

  typedef struct packed {
    logic              tag;
    logic [DATA_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/snoop_match.sv
`timescale 1ns/1ps
module snoop_match #(
  parameter int ADDR_W   = 16,
  parameter int DW_BYTES = 4
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] port1_i,
  input  logic [ADDR_W-1:0] port2_i,
  input  logic              en1_i,
  input  logic              en2_i,
  input  logic              dword_i,
  output logic              hit_o,
  output logic              tag_o
);
  localparam logic [ADDR_W-1:0] WIN  = ADDR_W'(DW_BYTES);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DW_BYTES - 1);

  logic [ADDR_W-1:0] off;
  logic              hit1, hit2, win_hit;

  assign off     = addr_i - port1_i;
  assign win_hit = off < WIN;
  assign hit1    = en1_i && (addr_i == port1_i);
  assign hit2    = en2_i && (addr_i == port2_i);

  always_comb begin
    if (dword_i) begin
      hit_o = wr_i && win_hit;
      tag_o = off == LAST;
    end else begin
      hit_o = wr_i && (hit1 || hit2);
      tag_o = !hit1;  // port one has priority
    end
  end
endmodule

// File: rtl/snoop_fifo.sv
`timescale 1ns/1ps
module snoop_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = cnt_q == '0;
  assign full_o  = cnt_q == CW'(DEPTH);
  assign count_o = cnt_q;
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign rdata_o = empty_o ? '0 : mem_q[rptr_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/snoop_edge_sync.sv
`timescale 1ns/1ps
module snoop_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic change_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign change_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/io_snoop_fifo.sv
`timescale 1ns/1ps
module io_snoop_fifo
  import snoop_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DW_BYTES = 4,
  parameter int SYNC_N   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              host_rst_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [OFS_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int EW = $bits(entry_t);
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] port1_q, port2_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              ovf_q, hflag_q;

  logic   hit, tag, push, pop, empty, full, hchg, hclr, stat_rd;
  entry_t wentry, head;
  logic [EW-1:0] head_raw;
  logic [CW-1:0] count;

  snoop_match #(.ADDR_W(ADDR_W), .DW_BYTES(DW_BYTES)) i_match (
    .wr_i    (host_wr_i),
    .addr_i  (host_addr_i),
    .port1_i (port1_q),
    .port2_i (port2_q),
    .en1_i   (ctrl_q[CTL_P1_EN]),
    .en2_i   (ctrl_q[CTL_P2_EN]),
    .dword_i (ctrl_q[CTL_DWORD]),
    .hit_o   (hit),
    .tag_o   (tag)
  );

  assign wentry = '{tag: tag, data: host_data_i};
  assign pop    = reg_rd_i && (reg_addr_i == OFS_DATA) && !empty;
  assign push   = hit && (!full || pop);

  snoop_fifo #(.DEPTH(DEPTH), .WIDTH(EW)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wentry),
    .pop_i   (pop),
    .rdata_o (head_raw),
    .empty_o (empty),
    .full_o  (full),
    .count_o (count)
  );
  assign head = entry_t'(head_raw);

  snoop_edge_sync #(.STAGES(SYNC_N)) i_hsync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_i  (host_rst_i),
    .change_o (hchg)
  );

  assign stat_rd = reg_rd_i && (reg_addr_i == OFS_STAT);
  assign hclr    = reg_wr_i && (reg_addr_i == OFS_HRST) && reg_wdata_i[HR_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port1_q <= '0;
      port2_q <= '0;
      ctrl_q  <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        OFS_P1_LO: port1_q[7:0]        <= reg_wdata_i;
        OFS_P1_HI: port1_q[ADDR_W-1:8] <= reg_wdata_i;
        OFS_P2_LO: port2_q[7:0]        <= reg_wdata_i;
        OFS_P2_HI: port2_q[ADDR_W-1:8] <= reg_wdata_i;
        OFS_CTRL:  ctrl_q              <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q   <= 1'b0;
      hflag_q <= 1'b0;
    end else begin
      if (hit && full && !pop) ovf_q <= 1'b1;
      else if (stat_rd && empty) ovf_q <= 1'b0;
      if (hchg)      hflag_q <= 1'b1;
      else if (hclr) hflag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_P1_LO: reg_rdata_o = port1_q[7:0];
      OFS_P1_HI: reg_rdata_o = port1_q[ADDR_W-1:8];
      OFS_P2_LO: reg_rdata_o = port2_q[7:0];
      OFS_P2_HI: reg_rdata_o = port2_q[ADDR_W-1:8];
      OFS_CTRL:  reg_rdata_o = ctrl_q;
      OFS_STAT: begin
        reg_rdata_o[ST_VALID] = !empty;
        reg_rdata_o[ST_OVF]   = ovf_q;
        reg_rdata_o[ST_TAG]   = !empty && head.tag;
      end
      OFS_DATA:  reg_rdata_o = head.data;
      OFS_HRST:  reg_rdata_o[HR_FLAG] = hflag_q;
      default: ;
    endcase
  end

  assign irq_o = (!empty && ctrl_q[CTL_RDY_IE]) || (hflag_q && ctrl_q[CTL_HRST_IE]);
endmodule

// File: rtl/snoop_chk.sv
`timescale 1ns/1ps
module snoop_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] count_i,
  input logic          full_i,
  input logic          push_i,
  input logic          pop_i,
  input logic          empty_i,
  input logic          ovf_i,
  input logic          flag_i,
  input logic          chg_i,
  input logic          clr_i,
  input logic          irq_i
);
  // R6
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  // R6
  ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> $past(full_i));

  // R5
  pop_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (count_i == $past(count_i) - 1'b1));

  // R9
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(chg_i));

  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !chg_i) |=> !flag_i);

  // R11
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_i && !flag_i) |-> !irq_i);
endmodule

bind io_snoop_fifo snoop_chk #(.DEPTH(DEPTH)) i_snoop_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .count_i (count),
  .full_i  (full),
  .push_i  (push),
  .pop_i   (pop),
  .empty_i (empty),
  .ovf_i   (ovf_q),
  .flag_i  (hflag_q),
  .chg_i   (hchg),
  .clr_i   (hclr),
  .irq_i   (irq_o)
);

// File: tb/test_io_snoop_fifo.sv
`timescale 1ns/1ps
module test_io_snoop_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_data = '0;
  logic        host_rst = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  io_snoop_fifo i_io_snoop_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_addr_i(host_addr), .host_data_i(host_data),
    .host_rst_i(host_rst),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic hwr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic expect_pop(input string req, input logic [7:0] st, input logic [7:0] dat);
    logic [7:0] v;
    rd_reg(5'h08, v); chk({req, " status"}, v, st);
    rd_reg(5'h0A, v); chk({req, " data"}, v, dat);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(5'h06, v); chk("R1 ctrl", v, 8'h00);
    rd_reg(5'h08, v); chk("R1 status", v, 8'h00);
    rd_reg(5'h0C, v); chk("R1 hrst", v, 8'h00);
    rd_reg(5'h10, v); chk("R1 port1 lo", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ports();
    logic [7:0] v;
    wr_reg(5'h10, 8'h80); wr_reg(5'h12, 8'h00);
    wr_reg(5'h02, 8'h84); wr_reg(5'h04, 8'h00);
    wr_reg(5'h06, 8'hC0);
    rd_reg(5'h10, v); chk("R2 port1 lo", v, 8'h80);
    rd_reg(5'h02, v); chk("R2 port2 lo", v, 8'h84);
    rd_reg(5'h06, v); chk("R2 ctrl", v, 8'hC0);
  endtask

  task automatic t_normal();
    logic [7:0] v;
    hwr(16'h0080, 8'h11);
    hwr(16'h0084, 8'h22);
    hwr(16'h0081, 8'h33);
    hwr(16'h0180, 8'h44);
    expect_pop("R3 R4 port1 tag0", 8'h80, 8'h11);
    expect_pop("R3 R4 port2 tag1", 8'h81, 8'h22);
    rd_reg(5'h08, v); chk("R3 non-matching ignored", v, 8'h00);
    rd_reg(5'h0A, v); chk("R5 empty data read", v, 8'h00);
    rd_reg(5'h08, v); chk("R5 empty read no change", v, 8'h00);
    wr_reg(5'h06, 8'h80);
    hwr(16'h0084, 8'h55);
    rd_reg(5'h08, v); chk("R3 disabled port2", v, 8'h00);
    wr_reg(5'h02, 8'h80); wr_reg(5'h06, 8'hC0);
    hwr(16'h0080, 8'h66);
    expect_pop("R3 same port priority", 8'h80, 8'h66);
    wr_reg(5'h02, 8'h84);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr_reg(5'h06, 8'h80);
    for (int i = 0; i < 17; i++) hwr(16'h0080, 8'(i));
    rd_reg(5'h08, v); chk("R6 full with overflow", v, 8'hA0);
    rd_reg(5'h0A, v); chk("R6 oldest kept", v, 8'h00);
    rd_reg(5'h08, v); chk("R7 sticky while data", v, 8'hA0);
    for (int i = 1; i < 16; i++) begin
      rd_reg(5'h0A, v); chk("R5 R6 order", v, 8'(i));
    end
    rd_reg(5'h08, v); chk("R7 empty read shows ovf", v, 8'h20);
    rd_reg(5'h08, v); chk("R7 cleared", v, 8'h00);
  endtask

  task automatic t_dword();
    logic [7:0] v;
    wr_reg(5'h06, 8'h04);
    hwr(16'h0080, 8'hA0);
    hwr(16'h0081, 8'hA1);
    hwr(16'h0084, 8'hB0);
    hwr(16'h007F, 8'hB1);
    hwr(16'h0082, 8'hA2);
    hwr(16'h0083, 8'hA3);
    expect_pop("R8 byte0", 8'h80, 8'hA0);
    expect_pop("R8 byte1", 8'h80, 8'hA1);
    expect_pop("R8 byte2", 8'h80, 8'hA2);
    expect_pop("R8 last byte tagged", 8'h81, 8'hA3);
    rd_reg(5'h08, v); chk("R8 port2 and outside ignored", v, 8'h00);
  endtask

  task automatic t_hrst();
    logic [7:0] v;
    wr_reg(5'h06, 8'h10);
    @(negedge clk); host_rst = 1'b1;
    repeat (5) @(negedge clk);
    rd_reg(5'h0C, v); chk("R9 rising edge", v, 8'h40);
    chk("R11 irq on reset flag", {7'd0, irq}, 8'h01);
    wr_reg(5'h0C, 8'h00);
    rd_reg(5'h0C, v); chk("R10 write zero keeps", v, 8'h40);
    wr_reg(5'h0C, 8'h40);
    rd_reg(5'h0C, v); chk("R10 w1c", v, 8'h00);
    chk("R11 irq drops", {7'd0, irq}, 8'h00);
    @(negedge clk); host_rst = 1'b0;
    repeat (5) @(negedge clk);
    rd_reg(5'h0C, v); chk("R9 falling edge", v, 8'h40);
    wr_reg(5'h0C, 8'hFF);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr_reg(5'h06, 8'h88);
    chk("R11 idle low", {7'd0, irq}, 8'h00);
    hwr(16'h0080, 8'h77);
    chk("R11 ready irq", {7'd0, irq}, 8'h01);
    rd_reg(5'h0A, v); chk("R11 pop data", v, 8'h77);
    chk("R11 irq after drain", {7'd0, irq}, 8'h00);
    wr_reg(5'h06, 8'h80);
    hwr(16'h0080, 8'h78);
    chk("R11 masked", {7'd0, irq}, 8'h00);
    rd_reg(5'h0A, v); chk("R11 masked data", v, 8'h78);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    wr_reg(5'h08, 8'hFF);
    wr_reg(5'h0A, 8'hFF);
    wr_reg(5'h0E, 8'hFF);
    wr_reg(5'h1F, 8'hFF);
    rd_reg(5'h08, v); chk("R12 status untouched", v, 8'h00);
    rd_reg(5'h06, v); chk("R12 ctrl untouched", v, 8'h80);
    rd_reg(5'h10, v); chk("R12 port1 untouched", v, 8'h80);
    rd_reg(5'h02, v); chk("R12 port2 untouched", v, 8'h84);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ports();
    t_normal();
    t_overflow();
    t_dword();
    t_hrst();
    t_irq();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule